// File: doc/BRIEF.md
# Alternating Two-Channel Tone Burst Generator

This block produces short ultrasonic-style excitation bursts on two output pins, one pin at a time. Each burst is a fixed number of square-wave cycles. A burst on one channel is followed by a long silent gap, after which the other channel gets its burst. The pattern repeats without end. All timing is counted in pulses of a single-cycle tick enable, nominally one every 2.5 us. With the default parameters this gives 40 kHz cycles (five ticks high, five ticks low), three cycles per burst and a 4 ms gap of 1600 ticks.

One shared duration counter times every phase: high halves, low halves and the gap. A small sequencer counts the cycles in a burst and selects the channel. The level each pin will take next is settled in a shadow register ahead of time. At a tick, the shadow register is copied to the pins, so every output edge falls on a tick edge whatever decision path the sequencer took. A channel indicator shows which channel the current or most recent burst belongs to.

Top module: `tone_burst_gen`

## Requirements
- R1: While `rst_i` is high at a clock edge, both burst pins and `chan_o` become 0, even if `tick_i` is also high.
- R2: The first tick after reset drives channel 0 high, meaning `burst_o` = 2'b01, where bit i of `burst_o` is channel i.
- R3: Within a burst, each high half and each low half lasts exactly HALF_TICKS ticks (default 5). A high half is always followed by a low half.
- R4: A burst contains exactly CYCLES high pulses (default 3) on the active channel. No fourth pulse follows the third low half.
- R5: After the last low half of a burst, both pins stay low for GAP_TICKS further ticks (default 1600). This makes a run of HALF_TICKS+GAP_TICKS zero ticks between bursts.
- R6: Bursts alternate channel 0, channel 1, channel 0 and so on. `chan_o` holds the channel index of the current or most recent burst. It changes only on the tick where the new burst's first high appears. With the defaults, the pin state after tick k (counted from 1 after reset) is as follows. Take m=(k-1) mod 3260. The channel is m/1630 and r=m mod 1630. The channel's pin is high exactly when r<30 and (r/5) is even.
- R7: At most one burst pin is high at any time.
- R8: The outputs change only at clock edges where `tick_i` is high. Between ticks they hold.
- R9: Every clock edge with `tick_i` high counts as one tick. This includes ticks held high on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Time-base enable, one pulse per 2.5 us tick |
| burst_o | output | CHANNELS (2) | Burst pins, bit i is channel i |
| chan_o | output | 1 | Index of the channel of the current or last burst |

## Verification
The tick that ends a gap does three things in the same cycle: it switches the channel, it reloads the duration counter, and it raises the first high pulse of the next burst. An off-by-one here would show up either as a gap ending on the wrong channel or as a 1-tick sliver. The bench walks two full channel periods with tick spacings that include back-to-back ticks. After every tick it compares the pins and `chan_o` against a closed-form model of the tick index. Checkpoints sit at the 1630/1631 and 3260/3261 boundaries. A reset that arrives in the same cycle as a tick is applied at the end, and reset must win.

// File: rtl/tbg_pkg.sv
package tbg_pkg;

    typedef enum logic [1:0] {
        PH_HIGH = 2'd0,
        PH_LOW  = 2'd1,
        PH_GAP  = 2'd2
    } phase_e;

    // Only the high phase drives the selected pin.
    function automatic logic phase_drives(phase_e p);
        return p == PH_HIGH;
    endfunction

    // Width for an index ranging over n values, never below one bit.
    function automatic int idx_width(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tbg_dur_timer.sv
module tbg_dur_timer #(
    parameter int DUR_W   = 16,
    parameter int RST_VAL = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [DUR_W-1:0] load_val_i,
    output logic             expire_o
);
    logic [DUR_W-1:0] remain_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            remain_q <= DUR_W'(RST_VAL);
        end else if (load_i) begin
            remain_q <= load_val_i;
        end else if (tick_i && remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign expire_o = (remain_q == '0);
endmodule

// File: rtl/tbg_seq.sv
module tbg_seq
    import tbg_pkg::*;
#(
    parameter int CHANNELS   = 2,
    parameter int CYCLES     = 3,
    parameter int HALF_TICKS = 5,
    parameter int GAP_TICKS  = 1600,
    parameter int DUR_W      = 16,
    localparam int CH_W      = idx_width(CHANNELS),
    localparam int CYC_W     = idx_width(CYCLES)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    input  logic             expire_i,
    output logic             load_o,
    output logic [DUR_W-1:0] load_val_o,
    output phase_e           nxt_phase_o,
    output logic [CH_W-1:0]  nxt_ch_o
);
    localparam logic [DUR_W-1:0] HALF_LD = DUR_W'(HALF_TICKS - 1);
    localparam logic [DUR_W-1:0] GAP_LD  = DUR_W'(GAP_TICKS - 1);
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYCLES - 1);
    localparam logic [CH_W-1:0]  CH_LAST  = CH_W'(CHANNELS - 1);

    phase_e            phase_q, phase_d;
    logic [CYC_W-1:0]  cyc_q, cyc_d;
    logic [CH_W-1:0]   ch_q, ch_d;
    logic              step;

    assign step = tick_i && expire_i;

    always_comb begin
        phase_d    = phase_q;
        cyc_d      = cyc_q;
        ch_d       = ch_q;
        load_o     = 1'b0;
        load_val_o = HALF_LD;
        if (step) begin
            load_o = 1'b1;
            unique case (phase_q)
                PH_HIGH: begin
                    phase_d = PH_LOW;
                end
                PH_LOW: begin
                    if (cyc_q == CYC_LAST) begin
                        phase_d    = PH_GAP;
                        cyc_d      = '0;
                        load_val_o = GAP_LD;
                    end else begin
                        phase_d = PH_HIGH;
                        cyc_d   = cyc_q + 1'b1;
                    end
                end
                PH_GAP: begin
                    phase_d = PH_HIGH;
                    ch_d    = (ch_q == CH_LAST) ? '0 : ch_q + 1'b1;
                end
                default: begin
                    phase_d = PH_HIGH;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase_q <= PH_HIGH;
            cyc_q   <= '0;
            ch_q    <= '0;
        end else begin
            phase_q <= phase_d;
            cyc_q   <= cyc_d;
            ch_q    <= ch_d;
        end
    end

    assign nxt_phase_o = phase_d;
    assign nxt_ch_o    = ch_d;
endmodule

// File: rtl/tbg_shadow.sv
module tbg_shadow
    import tbg_pkg::*;
#(
    parameter int CHANNELS = 2,
    localparam int CH_W    = idx_width(CHANNELS)
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                tick_i,
    input  phase_e              nxt_phase_i,
    input  logic [CH_W-1:0]     nxt_ch_i,
    output logic [CHANNELS-1:0] pins_o,
    output logic [CH_W-1:0]     chan_o
);
    logic [CHANNELS-1:0] pat_d, shadow_q, pins_q;
    logic [CH_W-1:0]     sh_ch_q, chan_q;

    for (genvar i = 0; i < CHANNELS; i++) begin : g_pat
        assign pat_d[i] = phase_drives(nxt_phase_i) && (nxt_ch_i == CH_W'(i));
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            shadow_q <= CHANNELS'(1);
            sh_ch_q  <= '0;
            pins_q   <= '0;
            chan_q   <= '0;
        end else if (tick_i) begin
            pins_q   <= shadow_q;
            chan_q   <= sh_ch_q;
            shadow_q <= pat_d;
            sh_ch_q  <= nxt_ch_i;
        end
    end

    assign pins_o = pins_q;
    assign chan_o = chan_q;
endmodule

// File: rtl/tone_burst_gen.sv
module tone_burst_gen
    import tbg_pkg::*;
#(
    parameter int CHANNELS   = 2,
    parameter int CYCLES     = 3,
    parameter int HALF_TICKS = 5,
    parameter int GAP_TICKS  = 1600,
    parameter int DUR_W      = 16,
    localparam int CH_W      = idx_width(CHANNELS)
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                tick_i,
    output logic [CHANNELS-1:0] burst_o,
    output logic [CH_W-1:0]     chan_o
);
    logic             expire;
    logic             load;
    logic [DUR_W-1:0] load_val;
    phase_e           nxt_phase;
    logic [CH_W-1:0]  nxt_ch;

    tbg_dur_timer #(
        .DUR_W   (DUR_W),
        .RST_VAL (HALF_TICKS - 1)
    ) u_timer (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .tick_i     (tick_i),
        .load_i     (load),
        .load_val_i (load_val),
        .expire_o   (expire)
    );

    tbg_seq #(
        .CHANNELS   (CHANNELS),
        .CYCLES     (CYCLES),
        .HALF_TICKS (HALF_TICKS),
        .GAP_TICKS  (GAP_TICKS),
        .DUR_W      (DUR_W)
    ) u_seq (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .tick_i      (tick_i),
        .expire_i    (expire),
        .load_o      (load),
        .load_val_o  (load_val),
        .nxt_phase_o (nxt_phase),
        .nxt_ch_o    (nxt_ch)
    );

    tbg_shadow #(
        .CHANNELS (CHANNELS)
    ) u_shadow (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .tick_i      (tick_i),
        .nxt_phase_i (nxt_phase),
        .nxt_ch_i    (nxt_ch),
        .pins_o      (burst_o),
        .chan_o      (chan_o)
    );
endmodule

// File: rtl/tbg_checker.sv
module tbg_checker #(
    parameter int CHANNELS   = 2,
    parameter int HALF_TICKS = 5,
    parameter int GAP_TICKS  = 1600,
    parameter int CH_W       = 1
) (
    input logic                clk_i,
    input logic                rst_i,
    input logic                tick_i,
    input logic [CHANNELS-1:0] burst_o,
    input logic [CH_W-1:0]     chan_o
);
    logic        rst_d = 1'b0;
    logic        tick_d;
    logic [31:0] zero_run, high_run;

    always_ff @(posedge clk_i) begin
        rst_d <= rst_i;
        if (rst_d) begin
            a_r1_reset_clear: assert (burst_o == '0 && chan_o == '0)
                else $error("R1 outputs not cleared by reset");
        end
    end

    // Run lengths of ticks with all pins low / some pin high.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            tick_d   <= 1'b0;
            zero_run <= '0;
            high_run <= '0;
        end else begin
            tick_d <= tick_i;
            if (tick_d) begin
                if (burst_o == '0) begin
                    zero_run <= zero_run + 1;
                    high_run <= '0;
                end else begin
                    high_run <= high_run + 1;
                    zero_run <= '0;
                end
            end
        end
    end

    a_r7_onehot: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(burst_o));

    a_r8_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !tick_i |=> ($stable(burst_o) && $stable(chan_o)));

    a_r6_switch_start: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(chan_o) |-> (burst_o == (CHANNELS'(1) << chan_o)));

    a_r3_high_len: assert property (@(posedge clk_i) disable iff (rst_i)
        (tick_d && burst_o == '0 && high_run != 0) |-> (high_run == HALF_TICKS));

    a_r5_gap_len: assert property (@(posedge clk_i) disable iff (rst_i)
        (tick_d && burst_o != '0 && zero_run != 0)
        |-> (zero_run == HALF_TICKS || zero_run == HALF_TICKS + GAP_TICKS));
endmodule

bind tone_burst_gen tbg_checker #(
    .CHANNELS   (CHANNELS),
    .HALF_TICKS (HALF_TICKS),
    .GAP_TICKS  (GAP_TICKS),
    .CH_W       (CH_W)
) u_tbg_checker (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .tick_i  (tick_i),
    .burst_o (burst_o),
    .chan_o  (chan_o)
);

// File: tb/tone_burst_gen_bench.sv
module tone_burst_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF  = 5;
    localparam int NCYC  = 3;
    localparam int GAP   = 1600;
    localparam int BURST = 2 * HALF * NCYC;
    localparam int CHPER = BURST + GAP;
    localparam int FULL  = 2 * CHPER;
    localparam int NTICK = FULL + 2;

    // Checkpoints: tick index, expected burst_o, expected chan_o, requirement
    localparam int NCP = 13;
    localparam int CP [0:NCP-1][0:3] = '{
        '{1,    1, 0, 2},   // R2 first tick
        '{5,    1, 0, 3},   // R3 end of first high
        '{6,    0, 0, 3},   // R3 first low
        '{11,   1, 0, 4},   // R4 second pulse
        '{21,   1, 0, 4},   // R4 third pulse
        '{26,   0, 0, 4},   // R4 last low
        '{31,   0, 0, 5},   // R5 gap, no fourth pulse
        '{1630, 0, 0, 5},   // R5 last gap tick
        '{1631, 2, 1, 6},   // R6 channel 1 starts
        '{1656, 0, 1, 4},   // R4 last low on channel 1
        '{1661, 0, 1, 5},   // R5 gap on channel 1
        '{3260, 0, 1, 5},   // R5 end of second gap
        '{3261, 1, 0, 6}    // R6 back to channel 0
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] burst;
    logic       chan;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tone_burst_gen u_tone_burst_gen (
        .clk_i   (clk),
        .rst_i   (rst),
        .tick_i  (tick),
        .burst_o (burst),
        .chan_o  (chan)
    );

    task automatic check(input string req, input logic [1:0] ep, input logic ec);
        n_checks++;
        if (burst !== ep || chan !== ec) begin
            n_fail++;
            $display("FAIL %s: burst=%b chan=%b expected burst=%b chan=%b",
                     req, burst, chan, ep, ec);
        end
    endtask

    function automatic logic [2:0] model(input int k);
        int m, c, r;
        logic hi;
        m  = (k - 1) % FULL;
        c  = m / CHPER;
        r  = m % CHPER;
        hi = (r < BURST) && (((r / HALF) % 2) == 0);
        return {c[0], hi && c == 1, hi && c == 0};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        finish_run();
    end

    initial begin
        logic [2:0] e;
        repeat (3) @(negedge clk);
        check("R1 reset state", 2'b00, 1'b0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 no tick after reset", 2'b00, 1'b0);

        // R9: spacing varies, including consecutive ticks
        for (int k = 1; k <= NTICK; k++) begin
            int idle;
            tick = 1'b1;
            @(negedge clk);
            e = model(k);
            check("R6 sequence model (R3 R4 R5 R7 R9)", e[1:0], e[2]);
            for (int i = 0; i < NCP; i++) begin
                if (CP[i][0] == k)
                    check($sformatf("R%0d checkpoint", CP[i][3]),
                          2'(CP[i][1]), 1'(CP[i][2]));
            end
            tick = 1'b0;
            idle = (k % 7 == 0) ? 0 : (k % 3);
            if (idle > 0) begin
                repeat (idle) @(negedge clk);
                if (k % 50 == 1 || k == CHPER || k == CHPER + 1)
                    check("R8 hold between ticks", e[1:0], e[2]);
            end
        end

        // R1: reset coincident with a tick wins
        tick = 1'b1;
        rst  = 1'b1;
        @(negedge clk);
        check("R1 reset beats tick", 2'b00, 1'b0);
        @(negedge clk);
        rst  = 1'b0;
        tick = 1'b0;
        @(negedge clk);
        check("R1 cleared after reset", 2'b00, 1'b0);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        check("R2 restart on channel 0", 2'b01, 1'b0);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule